// File: doc/BRIEF.md
# Refresh Interval Timer with Compare Match

This block is an 8-bit up-counter. It either paces DRAM refresh requests or runs as a general interval timer. A 3-bit clock-select field turns counting on and picks a prescaled tick from a parameter table of divisors. On every tick the count is checked against a compare register. When the two are equal, the counter returns to zero and a sticky match flag is set. The interrupt output is that flag gated by an enable bit. When refresh is enabled, each match also produces a one-clock refresh-request pulse.

Software reaches the block through a small word-wide register port. There is one write strobe, one read strobe, a 2-bit address and a combinational read-data path. The four locations are the count, the compare value, a control/status word and a refresh-enable word. Counting starts as soon as a nonzero select is written. If software sets a compare value below the current count, the counter runs through 0xFF and back to zero before the first match. The usual cure is to write 0x00 to the count before starting.

Top module: `rfsh_timer`

## Requirements
- R1: After reset, all four locations read 0x00 and both `irq` and `rfsh_req` are low. The locations are: address 0 the count, address 1 the compare value, address 2 control/status, address 3 refresh enable in bit 0.
- R2: The control/status word holds the select in bits [2:0]. With a nonzero select code k, the count advances by one every DIV(k) clocks, wrapping 0xFF to 0x00. The default DIV values for codes 1 to 7 are 1, 2, 4, 8, 16, 32 and 64. With select 0 the count holds its value.
- R3: On a tick where the count equals the compare value, the count becomes 0x00 and the match flag (control/status bit 4) is set. The interval is therefore compare+1 ticks.
- R4: `irq` is high exactly while the match flag and the interrupt enable (control/status bit 3) are both 1.
- R5: The match flag is cleared only by writing 0 to bit 4 after control/status has been read while the flag was 1. Writing 1 to bit 4 has no effect. A match in the same clock as a clear leaves the flag set.
- R6: If the count is above the compare value when counting starts, the count passes through 0xFF to 0x00. The flag stays clear until the count truly equals the compare value.
- R7: A software write to the count takes effect in the clock it is issued and overrides an increment or a match clear in that clock. A write colliding with a match also suppresses the flag.
- R8: With refresh enable at 1, each match drives `rfsh_req` high for exactly the following clock. With refresh enable at 0, `rfsh_req` stays low.
- R9: Writing a nonzero select from the stopped state restarts the prescaler. The first increment happens DIV(k) clocks after the write edge; with code 1 that is the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Compare-match interrupt |
| rfsh_req | output | 1 | One-clock refresh request |

## Verification
A software write to the count and a compare match can land on the same clock edge. A clear of the match flag and a new match can also coincide. The bench provokes the first case by stopping the timer and zeroing the count, then starting it with a compare of 3. It issues the count write exactly three clocks later, when the count sits on the compare value. The judgement is that the written value appears, no flag is set and no refresh pulse follows. A behavioural reference model, stepped on every clock, checks these outcomes and every other read value and output cycle by cycle.

// File: rtl/rfsh_timer_pkg.sv
package rfsh_timer_pkg;
   typedef enum logic [1:0] {
      LOC_COUNT   = 2'd0,
      LOC_COMPARE = 2'd1,
      LOC_CTRL    = 2'd2,
      LOC_REFRESH = 2'd3
   } loc_e;

   function automatic loc_e decode_loc(input logic [1:0] a);
      return loc_e'(a);
   endfunction
endpackage

// File: rtl/rfsh_prescaler.sv
module rfsh_prescaler #(
   parameter int SEL_W = 3,
   parameter int DIV_W = 16,
   parameter logic [((1 << SEL_W) - 1) * DIV_W - 1:0] DIV_TABLE =
      {16'd64, 16'd32, 16'd16, 16'd8, 16'd4, 16'd2, 16'd1}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             restart,
   output logic             tick
);
   localparam int NSEL = 1 << SEL_W;

   logic [DIV_W-1:0] last_phase [NSEL];
   logic [DIV_W-1:0] phase_q;
   logic             at_end;

   for (genvar i = 0; i < NSEL; i++) begin : g_div
      if (i == 0) begin : g_stop
         assign last_phase[i] = '0;
      end else begin : g_run
         localparam logic [DIV_W-1:0] DIVISOR = DIV_TABLE[(i-1)*DIV_W +: DIV_W];
         if (DIVISOR == '0) begin : g_bad
            $error("rfsh_prescaler: divisor table entry %0d is zero", i);
         end
         assign last_phase[i] = DIVISOR - 1'b1;
      end
   end

   assign at_end = (phase_q == last_phase[sel]);
   assign tick   = (sel != '0) && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || (sel == '0) || at_end) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/rfsh_count.sv
module rfsh_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             match
);
   logic [CNT_W-1:0] count_q;

   assign match = tick && (count_q == cmp) && !load;
   assign count = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (match) begin
         count_q <= '0;
      end else if (tick) begin
         count_q <= count_q + 1'b1;
      end
   end
endmodule

// File: rtl/rfsh_regs.sv
module rfsh_regs
   import rfsh_timer_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             match,
   output logic [CNT_W-1:0] cmp,
   output logic [SEL_W-1:0] sel,
   output logic             cmie,
   output logic             flag,
   output logic             ren,
   output logic             cnt_wr,
   output logic             sel_restart
);
   localparam int CMIE_BIT = SEL_W;
   localparam int FLAG_BIT = SEL_W + 1;

   loc_e loc;
   logic ctrl_wr;
   logic clear_ok;
   logic arm_q;

   assign loc         = decode_loc(addr);
   assign ctrl_wr     = wr_en && (loc == LOC_CTRL);
   assign cnt_wr      = wr_en && (loc == LOC_COUNT);
   assign clear_ok    = ctrl_wr && !wdata[FLAG_BIT] && arm_q;
   assign sel_restart = ctrl_wr && (wdata[SEL_W-1:0] != sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp  <= '0;
         sel  <= '0;
         cmie <= 1'b0;
         ren  <= 1'b0;
      end else if (wr_en) begin
         case (loc)
            LOC_COMPARE: cmp <= wdata;
            LOC_CTRL: begin
               sel  <= wdata[SEL_W-1:0];
               cmie <= wdata[CMIE_BIT];
            end
            LOC_REFRESH: ren <= wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         arm_q <= 1'b0;
      end else begin
         if (match) begin
            flag <= 1'b1;
         end else if (clear_ok) begin
            flag <= 1'b0;
         end
         if (rd_en && (loc == LOC_CTRL) && flag) begin
            arm_q <= 1'b1;
         end else if (clear_ok) begin
            arm_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer
   import rfsh_timer_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3,
   parameter int DIV_W = 16,
   parameter logic [((1 << SEL_W) - 1) * DIV_W - 1:0] DIV_TABLE =
      {16'd64, 16'd32, 16'd16, 16'd8, 16'd4, 16'd2, 16'd1}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             irq,
   output logic             rfsh_req
);
   if (SEL_W < 1) begin : g_bad_sel
      $error("rfsh_timer: SEL_W must be at least 1");
   end
   if (CNT_W < SEL_W + 2) begin : g_bad_cnt
      $error("rfsh_timer: CNT_W too narrow for the control/status word");
   end

   logic [CNT_W-1:0] cmp_q;
   logic [SEL_W-1:0] sel_q;
   logic             cmie_q;
   logic             flag_q;
   logic             ren_q;
   logic             cnt_wr;
   logic             sel_restart;
   logic             tick;
   logic             match;
   logic [CNT_W-1:0] count;
   logic             req_q;

   rfsh_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .match(match), .cmp(cmp_q), .sel(sel_q), .cmie(cmie_q),
      .flag(flag_q), .ren(ren_q), .cnt_wr(cnt_wr), .sel_restart(sel_restart)
   );

   rfsh_prescaler #(.SEL_W(SEL_W), .DIV_W(DIV_W), .DIV_TABLE(DIV_TABLE)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(sel_q), .restart(sel_restart), .tick(tick)
   );

   rfsh_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmp(cmp_q), .load(cnt_wr),
      .load_val(wdata), .count(count), .match(match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         req_q <= match && ren_q;
      end
   end

   always_comb begin
      rdata = '0;
      case (decode_loc(addr))
         LOC_COUNT:   rdata = count;
         LOC_COMPARE: rdata = cmp_q;
         LOC_CTRL: begin
            rdata[SEL_W-1:0] = sel_q;
            rdata[SEL_W]     = cmie_q;
            rdata[SEL_W+1]   = flag_q;
         end
         LOC_REFRESH: rdata[0] = ren_q;
         default: rdata = '0;
      endcase
   end

   assign irq      = flag_q && cmie_q;
   assign rfsh_req = req_q;
endmodule

// File: rtl/rfsh_timer_chk.sv
module rfsh_timer_chk #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] sel,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] wdata,
   input logic             match,
   input logic [CNT_W-1:0] count,
   input logic             flag,
   input logic             cmie,
   input logic             irq,
   input logic             ren,
   input logic             rfsh_req
);
   assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0 && !cnt_wr) |=> $stable(count));

   assert_match_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (count == '0));

   assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> flag);

   assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cmie && flag));

   assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count == $past(wdata)));

   assert_req_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_req |-> $past(ren));
endmodule

bind rfsh_timer rfsh_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel_q), .cnt_wr(cnt_wr), .wdata(wdata),
   .match(match), .count(count), .flag(flag_q), .cmie(cmie_q), .irq(irq),
   .ren(ren_q), .rfsh_req(rfsh_req)
);

// File: tb/rfsh_timer_tb.sv
`timescale 1ns/1ps
module rfsh_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;
   logic       rfsh_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   rfsh_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .rfsh_req(rfsh_req)
   );

   // behavioural reference model
   int divs [8] = '{0, 1, 2, 4, 8, 16, 32, 64};
   int m_cnt, m_cmp, m_sel, m_pcnt;
   bit m_cmie, m_flag, m_arm, m_ren, m_req;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_sel = 0; m_pcnt = 0;
         m_cmie = 0; m_flag = 0; m_arm = 0; m_ren = 0; m_req = 0;
      end else begin
         bit tick, hit, ctrl_w, clr;
         int nsel;
         tick   = (m_sel != 0) && (m_pcnt == divs[m_sel] - 1);
         hit    = tick && (m_cnt == m_cmp) && !(wr_en && addr == 2'd0);
         ctrl_w = wr_en && addr == 2'd2;
         nsel   = int'(wdata[2:0]);
         clr    = ctrl_w && !wdata[4] && m_arm;
         if (ctrl_w && nsel != m_sel) m_pcnt = 0;
         else if (m_sel == 0 || tick) m_pcnt = 0;
         else m_pcnt = m_pcnt + 1;
         if (wr_en && addr == 2'd0) m_cnt = int'(wdata);
         else if (hit) m_cnt = 0;
         else if (tick) m_cnt = (m_cnt + 1) % 256;
         m_req = hit && m_ren;
         if (rd_en && addr == 2'd2 && m_flag) m_arm = 1;
         else if (clr && !hit) m_arm = 0;
         else if (clr) m_arm = 0;
         if (hit) m_flag = 1;
         else if (clr) m_flag = 0;
         if (wr_en && addr == 2'd1) m_cmp = int'(wdata);
         if (ctrl_w) begin m_sel = nsel; m_cmie = wdata[3]; end
         if (wr_en && addr == 2'd3) m_ren = wdata[0];
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         int exp_rd;
         case (addr)
            2'd0: exp_rd = m_cnt;
            2'd1: exp_rd = m_cmp;
            2'd2: exp_rd = (int'(m_flag) << 4) | (int'(m_cmie) << 3) | m_sel;
            default: exp_rd = int'(m_ren);
         endcase
         check(addr == 2'd0 ? "R2 model count" : addr == 2'd2 ? "R5 model ctrl" :
               addr == 2'd3 ? "R8 model refresh enable" : "R1 model compare",
               int'(rdata), exp_rd);
         check("R4 model irq", int'(irq), int'(m_flag && m_cmie));
         check("R8 model rfsh_req", int'(rfsh_req), int'(m_req));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a);
      rd_en = 1'b1; addr = a;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      addr = a; #2; v = int'(rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int v, pulses;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         peek(2'(a), v); check("R1 reset read", v, 0);
      end
      check("R1 reset irq", int'(irq), 0);
      check("R1 reset rfsh_req", int'(rfsh_req), 0);

      // R9 / R2 start with code 1
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h01);
      peek(2'd0, v); check("R9 count at start", v, 0);
      idle(1); peek(2'd0, v); check("R9 first increment", v, 1);
      idle(4); peek(2'd0, v); check("R2 code1 rate", v, 5);
      wr(2'd2, 8'h00);
      idle(5); peek(2'd0, v); check("R2 hold when stopped", v, 6);

      // R2 divisor for code 3
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h03);
      idle(20); peek(2'd0, v); check("R2 code3 divide by 4", v, 5);
      wr(2'd2, 8'h00);

      // R3 R4 R8 first match
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h05);
      wr(2'd3, 8'h01);
      wr(2'd2, 8'h09);
      idle(6);
      check("R8 refresh pulse", int'(rfsh_req), 1);
      check("R4 irq on match", int'(irq), 1);
      peek(2'd0, v); check("R3 count cleared", v, 0);
      idle(1);
      check("R8 pulse one clock", int'(rfsh_req), 0);
      peek(2'd0, v); check("R3 count restarts", v, 1);

      // R5 flag clear protocol
      wr(2'd2, 8'h18);
      peek(2'd2, v); check("R5 write one no effect", v, 8'h18);
      wr(2'd2, 8'h08);
      peek(2'd2, v); check("R5 clear needs read", v, 8'h18);
      rd(2'd2);
      wr(2'd2, 8'h08);
      peek(2'd2, v); check("R5 clear after read", v, 8'h08);
      check("R4 irq low after clear", int'(irq), 0);

      // R6 compare below count
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h80);
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h09);
      idle(140);
      peek(2'd2, v); check("R6 no early flag", v & 8'h10, 0);
      peek(2'd0, v); check("R6 count wrapped", v, 8'h0C);
      idle(5);
      peek(2'd2, v); check("R6 flag at true match", v & 8'h10, 8'h10);
      peek(2'd0, v); check("R6 count cleared", v, 0);

      // R7 count write colliding with a match
      wr(2'd2, 8'h00);
      rd(2'd2);
      wr(2'd2, 8'h08);
      wr(2'd3, 8'h01);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h03);
      wr(2'd2, 8'h09);
      idle(3);
      peek(2'd0, v); check("R7 count on compare", v, 3);
      wr(2'd0, 8'h20);
      peek(2'd0, v); check("R7 write wins", v, 8'h20);
      peek(2'd2, v); check("R7 no flag on collision", v, 8'h09);
      check("R7 no refresh on collision", int'(rfsh_req), 0);

      // R8 refresh enable off / on
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h00);
      pulses = 0;
      for (int i = 0; i < 40; i++) begin idle(1); pulses += int'(rfsh_req); end
      check("R8 no pulses when disabled", pulses, 0);
      peek(2'd2, v); check("R3 matches still flag", v & 8'h10, 8'h10);
      wr(2'd3, 8'h01);
      pulses = 0;
      for (int i = 0; i < 40; i++) begin idle(1); pulses += int'(rfsh_req); end
      check("R8 pulse per match", pulses, 10);

      idle(2);
      finish_run();
   end
endmodule